// File: doc/BRIEF.md
# Multi-Mode Shift-Register Counter

This block is an N-bit counter built from a shift register. On each enabled clock every bit moves one place toward the top, so bit i takes the old bit i-1. Bit 0 is refilled from a feedback function of the present state. A two-bit mode input selects one of four feedback functions: a plain rotating ring, a one-hot ring that repairs itself, a one-cold ring that repairs itself, and a twisted (Johnson) ring. The result is a cyclic state machine whose states can serve as timing phases for control logic.

A combinational flag reports whether the current state lies on the intended cycle of the selected mode. The two self-repairing modes guarantee that any corrupted state rejoins the intended cycle. The plain ring and twisted modes do not repair themselves, and the flag exposes any state they keep that lies off the cycle. Every pin is a plain control or status signal. No data stream crosses the block edge, so there is no handshake and no back-pressure.

Top module: `shift_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state loads the start state of the mode on `mode_i`. That is 0...01 for modes 0 and 1, 1...10 for mode 2, and all zeros for mode 3. Bit 0 of `count_o` is the rightmost digit.
- R2: When `en_i` is low and `rst` is low, `count_o` keeps its value across the clock edge.
- R3: On an enabled edge, `count_o[i]` takes the previous `count_o[i-1]` for every i from 1 to N-1.
- R4: Mode 0 (plain ring) loads `count_o[0]` with the previous `count_o[N-1]`. In this mode a state that is not one-hot stays off the cycle, and `valid_o` stays low.
- R5: Mode 1 (self-repairing one-hot) loads `count_o[0]` with the NOR of bits 0 through N-2. From any of the 2^N states, `count_o` holds exactly one 1 within N enabled clocks, and it keeps exactly one 1 afterwards.
- R6: Mode 2 (self-repairing one-cold) loads `count_o[0]` with the NAND of bits 0 through N-2. From any of the 2^N states, `count_o` holds exactly one 0 within N enabled clocks, and it keeps exactly one 0 afterwards.
- R7: Mode 3 (twisted ring) loads `count_o[0]` with the inverse of the previous `count_o[N-1]`. Starting from all zeros, it returns to all zeros after exactly 2N enabled clocks. A state with more than one boundary between adjacent unequal bits stays off the cycle.
- R8: `valid_o` is high exactly when `count_o` is on the cycle of the present mode. For modes 0 and 1 that means exactly one 1. For mode 2 it means exactly one 0. For mode 3 it means at most one adjacent bit pair differs.
- R9: A change of `mode_i` does not alter the state by itself. The new feedback applies from the next enabled edge on, so switching between modes 0 and 3 from edge to edge can shift in any chosen bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads the start state of the present mode |
| mode_i | input | 2 | Feedback select: 0 plain ring, 1 one-hot repairing, 2 one-cold repairing, 3 twisted ring |
| en_i | input | 1 | Advance enable; when low the state holds |
| count_o | output | N | Present state, bit 0 is the shift input end |
| valid_o | output | 1 | High when the present state lies on the cycle of the present mode |

## Verification
The bench steps each mode from its reset state and follows the full cycle: N states for the one-hot and one-cold rings, and 2N for the twisted ring. This separates correct feedback and shift direction from a rotation in the wrong direction or a wrong inversion. It then writes arbitrary patterns into the register by picking the plain or twisted feedback on each edge. Every one of the 2^N states is tried as the start for both repairing modes, and each next state is predicted from the NOR or NAND rule, which tells the correct gate apart from a gate with the wrong span or polarity. Off-cycle patterns run under the plain ring and twisted modes, together with a held enable, to show that those modes keep bad states and that the flag tells on-cycle states from off-cycle ones.

// File: rtl/shc_pkg.sv
package shc_pkg;

  typedef enum logic [1:0] {
    MODE_RING    = 2'd0,
    MODE_ONEHOT  = 2'd1,
    MODE_ONECOLD = 2'd2,
    MODE_TWISTED = 2'd3
  } shc_mode_e;

endpackage

// File: rtl/shc_feedback.sv
module shc_feedback
  import shc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] q,
  input  shc_mode_e    mode,
  output logic         fb
);

  localparam int LOW_W = N - 1;

  logic [LOW_W-1:0] low_bits;
  logic             any_low_set;
  logic             all_low_set;

  assign low_bits    = q[LOW_W-1:0];
  assign any_low_set = |low_bits;
  assign all_low_set = &low_bits;

  always_comb begin
    unique case (mode)
      MODE_RING:    fb = q[N-1];
      MODE_ONEHOT:  fb = ~any_low_set;
      MODE_ONECOLD: fb = ~all_low_set;
      MODE_TWISTED: fb = ~q[N-1];
      default:      fb = q[N-1];
    endcase
  end

endmodule

// File: rtl/shc_validity.sv
module shc_validity
  import shc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] q,
  input  shc_mode_e    mode,
  output logic         valid
);

  localparam int CNT_W = $clog2(N + 1);

  logic [N-2:0]     edges;
  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] zeros_cnt;
  logic [CNT_W-1:0] edge_cnt;

  for (genvar g = 0; g < N - 1; g++) begin : g_edge
    assign edges[g] = q[g] ^ q[g+1];
  end

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < N; i++) ones_cnt = ones_cnt + CNT_W'(q[i]);
    zeros_cnt = CNT_W'(N) - ones_cnt;
    edge_cnt = '0;
    for (int i = 0; i < N - 1; i++) edge_cnt = edge_cnt + CNT_W'(edges[i]);
  end

  always_comb begin
    unique case (mode)
      MODE_RING,
      MODE_ONEHOT:  valid = (ones_cnt == CNT_W'(1));
      MODE_ONECOLD: valid = (zeros_cnt == CNT_W'(1));
      MODE_TWISTED: valid = (edge_cnt <= CNT_W'(1));
      default:      valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/shc_state_reg.sv
module shc_state_reg
  import shc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  shc_mode_e    mode,
  input  logic         fb,
  output logic [N-1:0] q
);

  localparam logic [N-1:0] START_HOT  = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] START_COLD = ~START_HOT;
  localparam logic [N-1:0] START_TWIST = '0;

  logic [N-1:0] start_state;

  always_comb begin
    unique case (mode)
      MODE_ONECOLD: start_state = START_COLD;
      MODE_TWISTED: start_state = START_TWIST;
      default:      start_state = START_HOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= start_state;
    else if (en) q <= {q[N-2:0], fb};
  end

  // R1: reset picks the start state per mode
  p_reset_twist_r1: assert property (@(posedge clk)
    (rst && mode == MODE_TWISTED) |=> (q == '0));
  p_reset_cold_r1: assert property (@(posedge clk)
    (rst && mode == MODE_ONECOLD) |=> ($countones(~q) == 1 && !q[0]));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> (q[N-1:1] == $past(q[N-2:0])));

  p_ring_r4: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_RING) |=> (q[0] == $past(q[N-1])));

  p_twist_r7: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_TWISTED) |=> (q[0] != $past(q[N-1])));

endmodule

// File: rtl/shift_counter.sv
module shift_counter
  import shc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_i,
  input  logic         en_i,
  output logic [N-1:0] count_o,
  output logic         valid_o
);

  shc_mode_e    mode;
  logic         fb;
  logic [N-1:0] state;

  assign mode = shc_mode_e'(mode_i);

  shc_feedback #(.N(N)) u_fb (
    .q    (state),
    .mode (mode),
    .fb   (fb)
  );

  shc_state_reg #(.N(N)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .en   (en_i),
    .mode (mode),
    .fb   (fb),
    .q    (state)
  );

  shc_validity #(.N(N)) u_val (
    .q     (state),
    .mode  (mode),
    .valid (valid_o)
  );

  assign count_o = state;

  // R5: once on the one-hot cycle, the repairing mode stays there
  p_hot_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode == MODE_ONEHOT && $onehot(count_o))
      |=> (mode_i != 2'd1) || $onehot(count_o));

  // R6: once on the one-cold cycle, the repairing mode stays there
  p_cold_closed_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode == MODE_ONECOLD && $onehot(~count_o))
      |=> (mode_i != 2'd2) || $onehot(~count_o));

  // R8: one-hot modes flag validity by the one-hot property
  p_valid_hot_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 || mode_i == 2'd1) |-> (valid_o == $onehot(count_o)));

endmodule

// File: tb/shift_counter_tb.sv
`timescale 1ns/1ps
module shift_counter_tb_top;

  localparam int N = 4;
  localparam int NSTATES = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_i = 2'd0;
  logic         en_i = 1'b0;
  logic [N-1:0] count_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shift_counter #(.N(N)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .en_i    (en_i),
    .count_o (count_o),
    .valid_o (valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic bit exp_valid(input logic [N-1:0] v, input logic [1:0] m);
    int e = 0;
    for (int i = 0; i < N - 1; i++) e += int'(v[i] != v[i+1]);
    case (m)
      2'd0, 2'd1: return ones(v) == 1;
      2'd2:       return ones(v) == N - 1;
      default:    return e <= 1;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_next(input logic [N-1:0] v, input logic [1:0] m);
    logic b;
    case (m)
      2'd0:    b = v[N-1];
      2'd1:    b = ~|v[N-2:0];
      2'd2:    b = ~&v[N-2:0];
      default: b = ~v[N-1];
    endcase
    return {v[N-2:0], b};
  endfunction

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; en_i = 1'b0; mode_i = m;
    step();
    rst = 1'b0;
  endtask

  // R9: pick ring or twisted feedback per edge to shift in any pattern
  task automatic load_pattern(input logic [N-1:0] pat);
    logic [N-1:0] m;
    do_reset(2'd0);
    m = {{(N-1){1'b0}}, 1'b1};
    en_i = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      mode_i = (m[N-1] == pat[i]) ? 2'd0 : 2'd3;
      step();
      m = {m[N-2:0], pat[i]};
    end
    en_i = 1'b0;
    chk(count_o == pat, "R9 loaded pattern", int'(count_o), int'(pat));
  endtask

  task automatic t_reset();
    logic [N-1:0] starts [4];
    starts[0] = 4'b0001; starts[1] = 4'b0001;
    starts[2] = 4'b1110; starts[3] = 4'b0000;
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      chk(count_o == starts[m], "R1 reset state", int'(count_o), int'(starts[m]));
      chk(valid_o == 1'b1, "R8 start valid", int'(valid_o), 1);
    end
  endtask

  task automatic t_hold();
    do_reset(2'd1);
    en_i = 1'b1; step(); en_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(count_o == 4'b0010, "R2 hold", int'(count_o), 4'b0010);
    end
  endtask

  task automatic t_cycles(input logic [1:0] m, input int len);
    logic [N-1:0] exp, first;
    do_reset(m);
    exp = count_o; first = count_o;
    en_i = 1'b1;
    for (int k = 0; k < len; k++) begin
      step();
      exp = exp_next(exp, m);
      chk(count_o == exp, "R3 R4 R5 R6 R7 cycle step", int'(count_o), int'(exp));
      chk(valid_o == 1'b1, "R8 on cycle", int'(valid_o), 1);
    end
    chk(count_o == first, "R7 cycle length returns", int'(count_o), int'(first));
    en_i = 1'b0;
  endtask

  task automatic t_stuck(input logic [N-1:0] pat, input logic [1:0] m);
    logic [N-1:0] exp;
    load_pattern(pat);
    mode_i = m;
    step();
    chk(count_o == pat, "R9 mode change no effect", int'(count_o), int'(pat));
    exp = pat; en_i = 1'b1;
    for (int k = 0; k < 2 * N; k++) begin
      step();
      exp = exp_next(exp, m);
      chk(count_o == exp, "R4 R7 off-cycle step", int'(count_o), int'(exp));
      chk(valid_o == 1'b0, "R4 R7 R8 flag stays low", int'(valid_o), 0);
    end
    en_i = 1'b0;
  endtask

  task automatic t_repair(input logic [1:0] m);
    logic [N-1:0] exp;
    for (int s = 0; s < NSTATES; s++) begin
      load_pattern(N'(s));
      mode_i = m;
      @(negedge clk);
      chk(valid_o == exp_valid(count_o, m), "R8 flag matches", int'(valid_o),
          int'(exp_valid(count_o, m)));
      exp = N'(s); en_i = 1'b1;
      for (int k = 0; k < N; k++) begin
        step();
        exp = exp_next(exp, m);
        chk(count_o == exp, (m == 2'd1) ? "R5 next state" : "R6 next state",
            int'(count_o), int'(exp));
      end
      chk(valid_o == 1'b1 && exp_valid(count_o, m),
          (m == 2'd1) ? "R5 recovered in N" : "R6 recovered in N", int'(count_o), int'(exp));
      step();
      chk(exp_valid(count_o, m), (m == 2'd1) ? "R5 stays on cycle" : "R6 stays on cycle",
          int'(count_o), int'(exp_next(exp, m)));
      en_i = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_cycles(2'd0, N);
    t_cycles(2'd1, N);
    t_cycles(2'd2, N);
    t_cycles(2'd3, 2 * N);
    t_stuck(4'b0101, 2'd0);
    t_stuck(4'b0000, 2'd0);
    t_stuck(4'b1011, 2'd0);
    t_stuck(4'b0101, 2'd3);
    t_stuck(4'b1001, 2'd3);
    t_repair(2'd1);
    t_repair(2'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule